// File: doc/BRIEF.md
# Serial Dual DAC Setting Controller

This block receives commands over a three-wire serial link: a clock, an active-high chip select and a data input. It drives a serial data output that stands in high impedance whenever it is not selected. It keeps two 8-bit live setting registers that feed two DAC channels. Each live register has a stored copy that stands in for nonvolatile memory and is modelled here as plain flops. Every frame both reads and writes. The old live value of the addressed channel is shifted out while the replacement is shifted in, so a read removes the value from the register.

A frame opens with a 1 bit. Two address bits follow, then eight data bits, each field least significant bit first, and the link clock samples every bit on its rising edge. After the last data bit there are two gap cycles. The new value reaches the live register on the first gap cycle. A program request during either gap cycle copies that value into the stored copy. After the gap the value is dropped. Releasing chip select throws away all temporary settings and restores both live registers from their stored copies. The sequencing of the actual memory commit is left to a separate block, which receives the program request.

Top module: `sdac_ctrl`

## Requirements
- R1: While reset is held and after it is released, both live registers equal the stored copies' power-on values (channel 0 = 0x5A, channel 1 = 0xC3 by default). No link clock edge with chip select high is needed for this.
- R2: With chip select high, a 1 on din in the idle state starts a frame. The next two bits are the address, first bit A0 then A1. The next eight bits are data D0 first. Address A0=0,A1=1 selects channel 0 (`dac_o[7:0]`) and A0=1,A1=1 selects channel 1 (`dac_o[15:8]`).
- R3: The addressed live register keeps its old value through the D7 sampling edge. It takes the new value on the next rising edge.
- R4: After the A1 edge, dout_o presents the old live value of the addressed channel. Bit k of that value is valid at the rising edge that samples data bit Dk, for k = 0 to 7.
- R5: dout_oe_o is high while chip select is high and low while it is low.
- R6: Any rising edge with chip select low reloads both live registers from their stored copies.
- R7: A program request that is high at either of the two edges after D7 copies the frame's value into the addressed channel's stored copy.
- R8: A program request that first arrives after the two gap edges changes no stored copy.
- R9: din is ignored on the two edges after D7. A start bit is accepted no earlier than the third edge after D7.
- R10: A frame cut short by dropping chip select changes nothing and leaves the receiver waiting for a start bit.
- R11: A frame whose A1 bit is 0 shifts out zeros and changes no live register or stored copy, even if a program request comes with it.
- R12: 0 bits on din while idle with chip select high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial link clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_i | input | 1 | Chip select, active high; low restores live registers |
| din_i | input | 1 | Serial data in |
| prog_i | input | 1 | Program request toward the stored copies |
| dout_o | output | 1 | Serial data out value |
| dout_oe_o | output | 1 | Output enable of the data out driver (low = high impedance) |
| dac_o | output | 16 | Live settings, channel 0 in the low byte |

## Verification
The hardest case to reach from the ports is a start bit that falls inside the two-cycle gap. It cannot be seen directly, because an accepted false start only shows up later as a misaligned frame. The bench holds din at 1 through both gap edges and then sends a second frame to the other channel right at the earliest legal edge. Both channels must end with the values intended for them, and the old value read back must be correct. The stored copies cannot be observed directly either. Each commit or non-commit is therefore shown by dropping chip select and reading the restored live values.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Address field width; the top bit marks a live channel, the rest index it
  localparam int unsigned SDAC_AW = 2;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_ADDR,
    RX_DATA,
    RX_GAP
  } rx_state_e;

  // A channel is addressed when the top address bit is set and the index fits
  function automatic logic chan_valid(input logic [SDAC_AW-1:0] a, input int nch);
    return a[SDAC_AW-1] && (int'(a[SDAC_AW-2:0]) < nch);
  endfunction

  function automatic int chan_index(input logic [SDAC_AW-1:0] a);
    return int'(a[SDAC_AW-2:0]);
  endfunction

endpackage

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = SDAC_AW,
  parameter int GAP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          din_i,
  output logic          start_o,
  output logic          addr_done_o,
  output logic [AW-1:0] addr_cur_o,
  output logic [AW-1:0] addr_o,
  output logic          shift_o,
  output logic          frame_done_o,
  output logic [DW-1:0] word_o,
  output logic          in_gap_o,
  output logic          apply_o,
  output logic          gap_end_o
);

  localparam int MAXA = (DW > AW) ? DW : AW;
  localparam int MAXC = (GAP > MAXA) ? GAP : MAXA;
  localparam int CW   = $clog2(MAXC + 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  logic last_addr, last_data, last_gap;

  assign last_addr = (cnt_q == CW'(AW - 1));
  assign last_data = (cnt_q == CW'(DW - 1));
  assign last_gap  = (cnt_q == CW'(GAP - 1));

  // Fields arrive LSB first: shift in at the top, so the first bit lands at bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (!cs_i) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          if (din_i) begin
            state_q <= RX_ADDR;
            cnt_q   <= '0;
            addr_q  <= '0;
          end
        end
        RX_ADDR: begin
          addr_q <= {din_i, addr_q[AW-1:1]};
          if (last_addr) begin
            state_q <= RX_DATA;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          data_q <= {din_i, data_q[DW-1:1]};
          if (last_data) begin
            state_q <= RX_GAP;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_GAP: begin
          if (last_gap) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign start_o      = cs_i && (state_q == RX_IDLE) && din_i;
  assign addr_done_o  = cs_i && (state_q == RX_ADDR) && last_addr;
  assign addr_cur_o   = {din_i, addr_q[AW-1:1]};
  assign addr_o       = addr_q;
  assign shift_o      = cs_i && (state_q == RX_DATA);
  assign frame_done_o = cs_i && (state_q == RX_DATA) && last_data;
  assign word_o       = {din_i, data_q[DW-1:1]};
  assign in_gap_o     = cs_i && (state_q == RX_GAP);
  assign apply_o      = in_gap_o && (cnt_q == '0);
  assign gap_end_o    = in_gap_o && last_gap;

endmodule

// File: rtl/sdac_regbank.sv
module sdac_regbank
  import sdac_pkg::*;
#(
  parameter int                  NCH     = 2,
  parameter int                  DW      = 8,
  parameter int                  AW      = SDAC_AW,
  parameter logic [NCH*DW-1:0]   NV_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              prog_i,
  input  logic              frame_done_i,
  input  logic [DW-1:0]     word_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              apply_i,
  input  logic              in_gap_i,
  input  logic              gap_end_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rd_val_o,
  output logic              addr_ok_o,
  output logic              hold_vld_o,
  output logic [NCH*DW-1:0] live_o,
  output logic [NCH*DW-1:0] nv_o
);

  logic [DW-1:0] hold_q;
  logic          hold_vld_q;
  logic [DW-1:0] live_q [NCH];
  logic [DW-1:0] nv_q   [NCH];

  assign addr_ok_o  = chan_valid(addr_i, NCH);
  assign hold_vld_o = hold_vld_q;

  // Holding register: filled at D7, dropped when the gap ends or select falls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (!cs_i) begin
      hold_vld_q <= 1'b0;
    end else if (frame_done_i) begin
      hold_q     <= word_i;
      hold_vld_q <= 1'b1;
    end else if (gap_end_i) begin
      hold_vld_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit;
    assign hit = hold_vld_q && addr_ok_o && (chan_index(addr_i) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nv_q[g] <= NV_INIT[g*DW +: DW];
      end else if (prog_i && in_gap_i && hit) begin
        nv_q[g] <= hold_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[g] <= NV_INIT[g*DW +: DW];
      end else if (!cs_i) begin
        live_q[g] <= nv_q[g];
      end else if (apply_i && hit) begin
        live_q[g] <= hold_q;
      end
    end

    assign live_o[g*DW +: DW] = live_q[g];
    assign nv_o[g*DW +: DW]   = nv_q[g];
  end

  always_comb begin
    rd_val_o = '0;
    if (chan_valid(rd_addr_i, NCH)) begin
      for (int i = 0; i < NCH; i++) begin
        if (chan_index(rd_addr_i) == i) rd_val_o = live_q[i];
      end
    end
  end

endmodule

// File: rtl/sdac_dout.sv
module sdac_dout #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          shift_i,
  output logic          bit_o
);

  logic [DW-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (!cs_i) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= load_val_i;
    end else if (shift_i) begin
      sr_q <= {1'b0, sr_q[DW-1:1]};
    end
  end

  assign bit_o = sr_q[0];

endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int                NCH     = 2,
  parameter int                DW      = 8,
  parameter int                GAP     = 2,
  parameter logic [NCH*DW-1:0] NV_INIT = 16'hC35A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              din_i,
  input  logic              prog_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic [NCH*DW-1:0] dac_o
);

  localparam int AW = SDAC_AW;

  // Named internal events, also watched by the bound checker
  logic              start_w;
  logic              addr_done_w;
  logic [AW-1:0]     addr_cur_w;
  logic [AW-1:0]     addr_w;
  logic              shift_w;
  logic              frame_done_w;
  logic [DW-1:0]     word_w;
  logic              in_gap_w;
  logic              apply_w;
  logic              gap_end_w;
  logic [DW-1:0]     rd_val_w;
  logic              addr_ok_w;
  logic              hold_vld_w;
  logic [NCH*DW-1:0] nv_flat;
  logic              dout_bit_w;

  sdac_frame_rx #(.DW(DW), .AW(AW), .GAP(GAP)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_i         (cs_i),
    .din_i        (din_i),
    .start_o      (start_w),
    .addr_done_o  (addr_done_w),
    .addr_cur_o   (addr_cur_w),
    .addr_o       (addr_w),
    .shift_o      (shift_w),
    .frame_done_o (frame_done_w),
    .word_o       (word_w),
    .in_gap_o     (in_gap_w),
    .apply_o      (apply_w),
    .gap_end_o    (gap_end_w)
  );

  sdac_regbank #(.NCH(NCH), .DW(DW), .AW(AW), .NV_INIT(NV_INIT)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_i         (cs_i),
    .prog_i       (prog_i),
    .frame_done_i (frame_done_w),
    .word_i       (word_w),
    .addr_i       (addr_w),
    .apply_i      (apply_w),
    .in_gap_i     (in_gap_w),
    .gap_end_i    (gap_end_w),
    .rd_addr_i    (addr_cur_w),
    .rd_val_o     (rd_val_w),
    .addr_ok_o    (addr_ok_w),
    .hold_vld_o   (hold_vld_w),
    .live_o       (dac_o),
    .nv_o         (nv_flat)
  );

  sdac_dout #(.DW(DW)) u_dout (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_i       (cs_i),
    .load_i     (addr_done_w),
    .load_val_i (rd_val_w),
    .shift_i    (shift_w),
    .bit_o      (dout_bit_w)
  );

  assign dout_oe_o = cs_i;
  assign dout_o    = cs_i & dout_bit_w;

endmodule

// File: rtl/sdac_ctrl_chk.sv
module sdac_ctrl_chk #(
  parameter int NCH = 2,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_i,
  input logic              prog_i,
  input logic [NCH*DW-1:0] dac_o,
  input logic [NCH*DW-1:0] nv_flat,
  input logic              start_w,
  input logic              frame_done_w,
  input logic              in_gap_w,
  input logic              apply_w,
  input logic              addr_ok_w
);

  // A select-low edge leaves every live register equal to its stored copy
  p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> (dac_o == $past(nv_flat)));

  // Live registers move under select only on the first gap edge
  p_update_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dac_o) && $past(cs_i)) |-> $past(apply_w));

  // Stored copies move only under a program request inside the gap
  p_commit_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nv_flat) |-> $past(prog_i && in_gap_w));

  // No start bit is taken on the two edges after D7
  p_gap_edge0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_w |=> !start_w);
  p_gap_edge1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_w |=> ##1 !start_w);

  // A frame with no live channel leaves the outputs alone
  p_badaddr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_w && !addr_ok_w) |=> $stable(dac_o));

endmodule

bind sdac_ctrl sdac_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_i         (cs_i),
  .prog_i       (prog_i),
  .dac_o        (dac_o),
  .nv_flat      (nv_flat),
  .start_w      (start_w),
  .frame_done_w (frame_done_w),
  .in_gap_w     (in_gap_w),
  .apply_w      (apply_w),
  .addr_ok_w    (addr_ok_w)
);

// File: tb/sim_sdac_ctrl.sv
module sim_sdac_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0;
  logic        din = 1'b0;
  logic        prog = 1'b0;
  logic        dout;
  logic        dout_oe;
  logic [15:0] dac;

  int n_cmp = 0;
  int n_bad = 0;

  // Bench view of the channels, built from the requirements
  logic [7:0] live_m [2];
  logic [7:0] nv_m   [2];

  logic [7:0]  obs_old;
  logic [15:0] obs_pre;
  logic [15:0] obs_post;

  always #4 clk = ~clk;

  sdac_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_i      (cs),
    .din_i     (din),
    .prog_i    (prog),
    .dout_o    (dout),
    .dout_oe_o (dout_oe),
    .dac_o     (dac)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Drive one bit ahead of a rising edge; return at the following falling edge
  task automatic bit_cycle(input logic d);
    din = d;
    @(negedge clk);
  endtask

  // a = {A1, A0}; pg = -1 none, 0 first gap edge, 1 second gap edge
  task automatic frame(input logic [1:0] a, input logic [7:0] d, input int pg,
                       input logic gap_din);
    bit_cycle(1'b1);
    bit_cycle(a[0]);
    bit_cycle(a[1]);
    for (int k = 0; k < 8; k++) begin
      obs_old[k] = dout;
      bit_cycle(d[k]);
    end
    obs_pre = dac;
    prog = (pg == 0);
    bit_cycle(gap_din);
    obs_post = dac;
    prog = (pg == 1);
    bit_cycle(gap_din);
    prog = 1'b0;
    din  = 1'b0;
  endtask

  task automatic drop_cs();
    cs = 1'b0;
    bit_cycle(1'b0);
    live_m[0] = nv_m[0];
    live_m[1] = nv_m[1];
  endtask

  task automatic raise_cs();
    cs = 1'b1;
    bit_cycle(1'b0);
  endtask

  task automatic check_live(input string req);
    chk(req, int'(dac[7:0]),  int'(live_m[0]));
    chk(req, int'(dac[15:8]), int'(live_m[1]));
  endtask

  task automatic t_reset();
    nv_m[0] = 8'h5A; nv_m[1] = 8'hC3;
    live_m[0] = 8'h5A; live_m[1] = 8'hC3;
    #1;
    check_live("R1 during reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_live("R1 after reset");
    chk("R5 oe low while deselected", int'(dout_oe), 0);
    raise_cs();
    chk("R5 oe high while selected", int'(dout_oe), 1);
  endtask

  task automatic t_temp_writes();
    frame(2'b10, 8'h96, -1, 1'b0);
    chk("R4 old ch0 read", int'(obs_old), 8'h5A);
    chk("R3 ch0 held at D7", int'(obs_pre[7:0]), 8'h5A);
    chk("R3 ch0 new after D7", int'(obs_post[7:0]), 8'h96);
    live_m[0] = 8'h96;
    check_live("R2 write ch0");
    frame(2'b11, 8'h3C, -1, 1'b0);
    chk("R4 old ch1 read", int'(obs_old), 8'hC3);
    live_m[1] = 8'h3C;
    check_live("R2 write ch1");
    frame(2'b10, 8'h11, -1, 1'b0);
    chk("R4 destructive read shows temp value", int'(obs_old), 8'h96);
    live_m[0] = 8'h11;
    check_live("R2 rewrite ch0");
    drop_cs();
    check_live("R6 restore both");
    chk("R5 oe low after drop", int'(dout_oe), 0);
    raise_cs();
  endtask

  task automatic t_commit();
    frame(2'b11, 8'hE7, 0, 1'b0);
    live_m[1] = 8'hE7; nv_m[1] = 8'hE7;
    frame(2'b10, 8'h81, 1, 1'b0);
    live_m[0] = 8'h81; nv_m[0] = 8'h81;
    drop_cs();
    check_live("R7 commit on either gap edge");
    raise_cs();
  endtask

  task automatic t_late_prog();
    frame(2'b10, 8'h22, -1, 1'b0);
    prog = 1'b1;
    bit_cycle(1'b0);
    bit_cycle(1'b0);
    prog = 1'b0;
    drop_cs();
    check_live("R8 late program request ignored");
    raise_cs();
  endtask

  task automatic t_gap_start();
    frame(2'b10, 8'h0F, -1, 1'b1);
    frame(2'b11, 8'h99, -1, 1'b0);
    chk("R9 old ch1 after gap ones", int'(obs_old), int'(live_m[1]));
    live_m[0] = 8'h0F; live_m[1] = 8'h99;
    check_live("R9 gap bits ignored");
    drop_cs();
    raise_cs();
  endtask

  task automatic t_truncated();
    bit_cycle(1'b1);
    bit_cycle(1'b0);
    bit_cycle(1'b1);
    bit_cycle(1'b1);
    bit_cycle(1'b0);
    bit_cycle(1'b1);
    drop_cs();
    check_live("R10 cut frame no change");
    raise_cs();
    frame(2'b11, 8'h5B, -1, 1'b0);
    chk("R10 receiver realigned", int'(obs_old), int'(nv_m[1]));
    live_m[1] = 8'h5B;
    check_live("R10 next frame lands");
  endtask

  task automatic t_bad_addr();
    frame(2'b01, 8'hFF, 0, 1'b0);
    chk("R11 zeros shifted out", int'(obs_old), 0);
    check_live("R11 live untouched");
    drop_cs();
    check_live("R11 stored untouched");
    raise_cs();
  endtask

  task automatic t_idle_zeros();
    for (int i = 0; i < 5; i++) bit_cycle(1'b0);
    check_live("R12 idle zeros no change");
    frame(2'b11, 8'h7E, -1, 1'b0);
    chk("R12 frame after idle zeros", int'(obs_old), int'(nv_m[1]));
    live_m[1] = 8'h7E;
    check_live("R12 write after idle zeros");
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_temp_writes();
    t_commit();
    t_late_prog();
    t_gap_start();
    t_truncated();
    t_bad_addr();
    t_idle_zeros();
    summary();
    $finish;
  end

endmodule